// File: doc/BRIEF.md
# Embedded-Clock Receive Lock Supervisor

This block supervises lock on the receive side of a 10-bit embedded-clock serial link. The recovered frame words reach it from the clock and data recovery front end, one per `frame_stb` pulse. Each word comes with a flag that says whether its clock-framing bits were valid, and a second flag that says whether it was a sync pattern. The block works out whether the receiver is locked. It drives an active-low lock indicator and governs a 10-bit parallel output bus that stays in high impedance until the first lock.

Lock can be acquired in two ways. In the first, the transmitter sends sync patterns and two of them in a row are enough. In the second, the random search counts ordinary words with valid framing and declares lock after four of them in a row. Lock is dropped only after two consecutive words with invalid framing. After a loss the output bus stays enabled but keeps showing the last good word. A relock then raises a one-cycle suspect flag with the first new word, so downstream logic knows that data near the loss is questionable. A watchdog checks that the reference clock is running. If no reference edge arrives within 16 system cycles, the receiver is forced unlocked and the bus returns to high impedance.

The finite-state machine has three states:
- `ST_HUNT`: unlocked and searching.
- `ST_LOCKED`: locked, with the last word's framing valid.
- `ST_MISS1`: still locked, but one word with invalid framing has just been seen.

Its transitions are:
- `acquire`: HUNT to LOCKED, when the sync count or the random count completes on a strobe.
- `miss`: LOCKED to MISS1, on a word with invalid framing.
- `recover`: MISS1 to LOCKED, on a word with valid framing.
- `lose`: MISS1 to HUNT, on a second word with invalid framing.
- `refloss`: any state to HUNT, while the reference clock is absent.

Top module: `deser_lock_ctrl`

## Requirements
- R1: `lock_n` is 1 from reset until the first acquisition. It is 0 in the cycle after the strobe that completes acquisition and stays 0 while lock is held.
- R2: From reset until the first lock, `rout_oe` is 0 and `rout` is all high impedance. From the acquiring word onward, `rout_oe` is 1 and `rout` is driven.
- R3: While locked, a single word with `frame_ok`=0 leaves `lock_n` at 0. A second consecutive word with `frame_ok`=0 sets `lock_n` to 1.
- R4: Random lock requires 4 consecutive strobes with `frame_ok`=1. After 3 such strobes `lock_n` is still 1. A word with `frame_ok`=0 restarts the count.
- R5: Sync lock requires 2 consecutive strobes with `sync_det`=1. The second one sets `lock_n` to 0, even when the random count alone would not be complete.
- R6: Suppose no edge on `ref_clk` has been seen for 16 system cycles. Then the block goes unlocked, sets `rout_oe` to 0, puts `rout` in high impedance, and ignores acquisition patterns until an edge on `ref_clk` is seen again.
- R7: `suspect` is 1 for exactly one cycle, together with the first word shown after a relock that follows a loss of lock. It stays 0 on the first lock after reset or after the reference clock returns.
- R8: After a loss of lock with `rout_oe` at 1, `rout` stays frozen at the last word that had valid framing until the next acquisition. Words with `frame_ok`=0 are never shown on `rout`.
- R9: While locked, each word with `frame_ok`=1 appears on `rout` in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock, sampled for presence |
| frame_stb | input | 1 | One-cycle pulse: a recovered word is present |
| frame_word | input | 10 | Recovered parallel word |
| frame_ok | input | 1 | Clock-framing bits of this word were valid |
| sync_det | input | 1 | This word is a sync pattern |
| rout | output | 10 | Parallel data out, high impedance while disabled |
| rout_oe | output | 1 | Output bus enabled |
| lock_n | output | 1 | Active-low lock indicator |
| suspect | output | 1 | One-cycle flag: first word after a relock |

## Verification
The bench sends three valid words and then a bad one in the middle of a random search. A design that fails to restart the count, or that counts one word too few, would lock early. It also sends a single bad word while locked. A design that drops lock on one miss would raise `lock_n` there, and a design that loaded the bad word would show it on the frozen bus. The bench stops the reference clock while the receiver is locked, then tries to acquire without it. This exposes a missing or non-sticky watchdog and an output bus that stays driven. Finally, it checks that `suspect` appears only on a relock after a loss, and not on the first lock after the reference clock returns.

// File: rtl/deser_lock_pkg.sv
package deser_lock_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_MISS1  = 2'd2
    } lock_state_e;
endpackage

// File: rtl/deser_ref_watchdog.sv
module deser_ref_watchdog #(
    parameter int WD_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic ref_ok
);
    localparam int CW = $clog2(WD_LIMIT + 1);

    logic        s1, s2, s3;
    logic        edge_seen;
    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= ref_clk;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_seen = s2 ^ s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idle_cnt <= CW'(WD_LIMIT);
        else if (edge_seen)
            idle_cnt <= '0;
        else if (idle_cnt != CW'(WD_LIMIT))
            idle_cnt <= idle_cnt + 1'b1;
    end

    assign ref_ok = (idle_cnt != CW'(WD_LIMIT));

    // R6
    ref_expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ok && !edge_seen) |=> !ref_ok);
endmodule

// File: rtl/deser_acq_counter.sv
module deser_acq_counter #(
    parameter int NEED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic hit,
    output logic done_now
);
    localparam int CW = (NEED > 1) ? $clog2(NEED) : 1;
    localparam logic [CW-1:0] LAST = CW'(NEED - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (clear)
            run_cnt <= '0;
        else if (step) begin
            if (!hit)
                run_cnt <= '0;
            else if (run_cnt != LAST)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign done_now = !clear && step && hit && (run_cnt == LAST);

    // R4 R5
    acq_miss_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit) |=> !done_now || (NEED == 1));
endmodule

// File: rtl/deser_lock_fsm.sv
module deser_lock_fsm
    import deser_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ok,
    input  logic frame_stb,
    input  logic frame_ok,
    input  logic acq_done,
    output logic hunting,
    output logic lock_n,
    output logic load_word,
    output logic relock,
    output logic bus_en
);
    lock_state_e state_q, state_d;
    logic        ever_locked_q;

    always_comb begin
        state_d = state_q;
        if (!ref_ok)
            state_d = ST_HUNT;
        else if (frame_stb) begin
            unique case (state_q)
                ST_HUNT:   if (acq_done)  state_d = ST_LOCKED;
                ST_LOCKED: if (!frame_ok) state_d = ST_MISS1;
                ST_MISS1:  state_d = frame_ok ? ST_LOCKED : ST_HUNT;
                default:   state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_HUNT;
            ever_locked_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!ref_ok)
                ever_locked_q <= 1'b0;
            else if (state_q == ST_HUNT && state_d == ST_LOCKED)
                ever_locked_q <= 1'b1;
        end
    end

    always_comb begin
        hunting   = (state_q == ST_HUNT);
        lock_n    = hunting;
        bus_en    = ever_locked_q;
        load_word = 1'b0;
        relock    = 1'b0;
        if (ref_ok && frame_stb) begin
            unique case (state_q)
                ST_HUNT: begin
                    load_word = acq_done;
                    relock    = acq_done && ever_locked_q;
                end
                ST_LOCKED, ST_MISS1: load_word = frame_ok;
                default: load_word = 1'b0;
            endcase
        end
    end

    // R3
    single_miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && ref_ok) |=> (state_q != ST_HUNT));

    // R6
    no_lock_without_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_ok |=> (lock_n && !bus_en));
endmodule

// File: rtl/deser_out_stage.sv
module deser_out_stage #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         relock,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_q,
    output logic         suspect_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            suspect_q <= 1'b0;
        end else begin
            if (load)
                word_q <= word_in;
            suspect_q <= load && relock;
        end
    end

    // R7
    suspect_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspect_q |=> !suspect_q);
endmodule

// File: rtl/deser_lock_ctrl.sv
module deser_lock_ctrl #(
    parameter int W         = 10,
    parameter int RAND_NEED = 4,
    parameter int SYNC_NEED = 2,
    parameter int WD_LIMIT  = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_clk,
    input  logic         frame_stb,
    input  logic [W-1:0] frame_word,
    input  logic         frame_ok,
    input  logic         sync_det,
    output logic [W-1:0] rout,
    output logic         rout_oe,
    output logic         lock_n,
    output logic         suspect
);
    logic         ref_ok, hunting, acq_clear;
    logic         rand_done, sync_done;
    logic         load_word, relock;
    logic [W-1:0] word_q;

    deser_ref_watchdog #(.WD_LIMIT(WD_LIMIT)) wd_i (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_ok(ref_ok)
    );

    assign acq_clear = !hunting || !ref_ok;

    deser_acq_counter #(.NEED(RAND_NEED)) rand_cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(acq_clear), .step(frame_stb),
        .hit(frame_ok), .done_now(rand_done)
    );

    deser_acq_counter #(.NEED(SYNC_NEED)) sync_cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(acq_clear), .step(frame_stb),
        .hit(sync_det), .done_now(sync_done)
    );

    deser_lock_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .frame_stb(frame_stb),
        .frame_ok(frame_ok), .acq_done(rand_done || sync_done),
        .hunting(hunting), .lock_n(lock_n), .load_word(load_word),
        .relock(relock), .bus_en(rout_oe)
    );

    deser_out_stage #(.W(W)) out_i (
        .clk(clk), .rst_n(rst_n), .load(load_word), .relock(relock),
        .word_in(frame_word), .word_q(word_q), .suspect_q(suspect)
    );

    assign rout = rout_oe ? word_q : {W{1'bz}};

    // R8
    frozen_when_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_n && rout_oe && !frame_stb) |=> $stable(word_q));
endmodule

// File: tb/deser_lock_ctrl_tb_top.sv
module deser_lock_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       ref_run = 1'b1;
    logic       frame_stb = 1'b0;
    logic [9:0] frame_word = '0;
    logic       frame_ok = 1'b0;
    logic       sync_det = 1'b0;
    wire  [9:0] rout;
    logic       rout_oe, lock_n, suspect;

    int checks = 0;
    int errors = 0;
    int ref_div = 0;

    deser_lock_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .frame_stb(frame_stb),
        .frame_word(frame_word), .frame_ok(frame_ok), .sync_det(sync_det),
        .rout(rout), .rout_oe(rout_oe), .lock_n(lock_n), .suspect(suspect)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (ref_run) begin
            ref_div <= (ref_div == 2) ? 0 : ref_div + 1;
            if (ref_div == 2) ref_clk <= ~ref_clk;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [9:0] w, input logic ok, input logic sy);
        @(negedge clk);
        frame_stb = 1'b1; frame_word = w; frame_ok = ok; sync_det = sy;
        @(negedge clk);
        frame_stb = 1'b0; frame_ok = 1'b0; sync_det = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 reset lock_n", {31'd0, lock_n}, 32'd1);
        check("R2 reset oe", {31'd0, rout_oe}, 32'd0);
        check("R2 reset hiz", {22'd0, rout}, {22'd0, 10'bzzzzzzzzzz});
    endtask

    task automatic t_random_lock;
        send(10'h011, 1, 0); send(10'h012, 1, 0); send(10'h013, 1, 0);
        send(10'h0BD, 0, 0);
        check("R4 restart after bad", {31'd0, lock_n}, 32'd1);
        send(10'h021, 1, 0); send(10'h022, 1, 0); send(10'h023, 1, 0);
        check("R4 three not enough", {31'd0, lock_n}, 32'd1);
        check("R2 still hiz", {22'd0, rout}, {22'd0, 10'bzzzzzzzzzz});
        send(10'h024, 1, 0);
        check("R4 lock on fourth", {31'd0, lock_n}, 32'd0);
        check("R2 oe after lock", {31'd0, rout_oe}, 32'd1);
        check("R2 word shown", {22'd0, rout}, 32'h024);
        check("R7 no suspect on first lock", {31'd0, suspect}, 32'd0);
        send(10'h155, 1, 0);
        check("R9 follow word", {22'd0, rout}, 32'h155);
    endtask

    task automatic t_single_miss;
        send(10'h2AA, 0, 0);
        check("R3 one miss keeps lock", {31'd0, lock_n}, 32'd0);
        check("R8 bad word not shown", {22'd0, rout}, 32'h155);
        send(10'h0F0, 1, 0);
        check("R9 recover word", {22'd0, rout}, 32'h0F0);
    endtask

    task automatic t_loss_relock;
        send(10'h301, 0, 0); send(10'h302, 0, 0);
        check("R3 two misses drop", {31'd0, lock_n}, 32'd1);
        check("R8 oe stays", {31'd0, rout_oe}, 32'd1);
        check("R8 frozen", {22'd0, rout}, 32'h0F0);
        send(10'h3C3, 1, 1);
        check("R5 one sync not enough", {31'd0, lock_n}, 32'd1);
        check("R8 frozen in hunt", {22'd0, rout}, 32'h0F0);
        send(10'h3C4, 1, 1);
        check("R5 sync lock", {31'd0, lock_n}, 32'd0);
        check("R7 suspect on relock", {31'd0, suspect}, 32'd1);
        check("R7 relock word", {22'd0, rout}, 32'h3C4);
        idle(1);
        check("R7 suspect one cycle", {31'd0, suspect}, 32'd0);
    endtask

    task automatic t_ref_loss;
        ref_run = 1'b0;
        idle(30);
        check("R6 unlock on ref loss", {31'd0, lock_n}, 32'd1);
        check("R6 oe off", {31'd0, rout_oe}, 32'd0);
        check("R6 hiz", {22'd0, rout}, {22'd0, 10'bzzzzzzzzzz});
        send(10'h041, 1, 1); send(10'h042, 1, 1);
        send(10'h043, 1, 0); send(10'h044, 1, 0);
        check("R6 no acquire without ref", {31'd0, lock_n}, 32'd1);
        ref_run = 1'b1;
        idle(12);
        send(10'h051, 1, 0); send(10'h052, 1, 0);
        send(10'h053, 1, 0); send(10'h054, 1, 0);
        check("R6 acquire after ref returns", {31'd0, lock_n}, 32'd0);
        check("R7 no suspect after ref return", {31'd0, suspect}, 32'd0);
        check("R2 word after ref return", {22'd0, rout}, 32'h054);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(10);
        t_reset();
        t_random_lock();
        t_single_miss();
        t_loss_relock();
        t_ref_loss();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule